// File: doc/BRIEF.md
# Disk Drive Control and Status Registers

This block sits between a processor bus and a removable-media disk drive. Software writes a control byte that drives the drive's motor, stop and transfer-direction lines. The same byte also carries the name-table mirroring select and three strobes used by neighbouring logic: end-of-block checksum handling, gap/scan mode and the byte-transfer interrupt enable. A second writable byte drives an eight-bit open-collector expansion port.

Two read-only registers return the drive state and the expansion port. The drive state covers media present, media writable and a ready flag. The ready flag tracks the head-position line while the motor is commanded on. All drive-side inputs pass through a two-stage synchronizer before any edge detection or readback. The serial data path and the checksum engine live in other blocks.

Top module: `drive_ctl_regs`

## Requirements
- R1: After reset the control byte is 0x2E (stop line low, motor line high, direction read, mirroring vertical, checksum/scan/interrupt lines low) and the expansion output byte is 0xFF.
- R2: A write to offset 0x5 sets the control outputs from the data bits: bit 0 stop line (`drv_stop_n`), bit 2 direction (1 = read), bit 3 mirroring (1 = vertical), bit 4 checksum strobe, bit 6 scan/gap, bit 7 interrupt enable. Bit 5 is always stored as 1 whatever is written.
- R3: The motor line `drv_motor_n` is low only when control bit 0 is 1 and control bit 1 is 0. While bit 0 is 0, bit 1 has no effect.
- R4: With the motor commanded on, a falling edge of the synchronized head line clears the ready flag, read as bit 1 of the status byte at offset 0x2.
- R5: The ready flag returns to 1 once the synchronized head line is high again, which marks the inner end of travel.
- R6: While the motor is not commanded on, the ready flag is 1 one cycle later and head-line edges are ignored.
- R7: Status byte bit 0 is the synchronized media-present input (active low), bit 2 is the synchronized writable input (active low), bit 6 reads 1, and bits 3, 4, 5 and 7 read 0.
- R8: The expansion readback at offset 0x3 is the bitwise AND of the synchronized expansion inputs and the expansion output byte. Bit 7, which carries power-good, therefore reads 0 unless output bit 7 was written as 1.
- R9: A write to offset 0x6 loads the expansion output byte. Writes to any other offset change nothing. Reads at any offset other than 0x2 or 0x3 return 0.
- R10: A change on a drive-side input is visible at the readback after two rising clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| drv_stop_n | output | 1 | Motor stop line, active low |
| drv_motor_n | output | 1 | Motor run line, active low |
| drv_read | output | 1 | Transfer direction, 1 = read |
| mirror_vert | output | 1 | Mirroring select, 1 = vertical |
| crc_ctl | output | 1 | End-of-block checksum strobe |
| scan_gap | output | 1 | Gap/scan mode |
| xfer_irq_en | output | 1 | Byte-transfer interrupt enable |
| ext_out | output | 8 | Expansion port output byte |
| drv_present_n | input | 1 | Media present, active low |
| drv_head_n | input | 1 | Head position line, low from the outer track |
| drv_wren_n | input | 1 | Media writable, active low |
| ext_in | input | 8 | Expansion port inputs; bit 7 is power-good |

## Verification
The assertions check on every cycle that the stop line overrides the motor line and that the ready flag is set again once the motor is off. They also check that the flag only falls after a cycle with the motor on. For the read mux they check the fixed status bits, the masking of power-good by output bit 7, and zero data at unused offsets. The bench scenarios cover the behaviour that needs ordered stimulus: the ready flag clearing on a head-line edge and recovering at the inner end, the two-edge synchronizer latency, and sweeps of all control bytes and all expansion output bytes against several input patterns.

// File: rtl/drive_ctl_regs.sv
module drive_ctl_regs #(
  parameter int ADDR_W = 4,
  parameter int EXT_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] EXT_RD_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h5,
  parameter logic [ADDR_W-1:0] EXT_WR_ADDR = 4'h6,
  parameter logic [7:0] CTRL_RST = 8'h2E,
  parameter logic [EXT_W-1:0] EXT_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              drv_stop_n,
  output logic              drv_motor_n,
  output logic              drv_read,
  output logic              mirror_vert,
  output logic              crc_ctl,
  output logic              scan_gap,
  output logic              xfer_irq_en,
  output logic [EXT_W-1:0]  ext_out,
  input  logic              drv_present_n,
  input  logic              drv_head_n,
  input  logic              drv_wren_n,
  input  logic [EXT_W-1:0]  ext_in
);
  localparam int SW = EXT_W + 3;

  logic [7:0]       ctrl_q;
  logic [EXT_W-1:0] ext_q;
  logic [SW-1:0]    sync_q [SYNC_STAGES];
  logic [SW-1:0]    sync_s;
  logic             head_prev;
  logic             rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= {EXT_RST, 3'b111};
    end else begin
      sync_q[0] <= {ext_in, drv_wren_n, drv_head_n, drv_present_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sync_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ext_q  <= EXT_RST;
    end else if (wr_en) begin
      if (addr == CTRL_ADDR)   ctrl_q <= wdata | 8'h20;
      if (addr == EXT_WR_ADDR) ext_q  <= wdata[EXT_W-1:0];
    end
  end

  wire motor_run = ctrl_q[0] & ~ctrl_q[1];
  wire head_s    = sync_s[1];
  wire head_fall = head_prev & ~head_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_prev <= 1'b1;
      rdy_q     <= 1'b1;
    end else begin
      head_prev <= head_s;
      if (!motor_run)     rdy_q <= 1'b1;
      else if (head_fall) rdy_q <= 1'b0;
      else if (head_s)    rdy_q <= 1'b1;
    end
  end

  assign drv_stop_n  = ctrl_q[0];
  assign drv_motor_n = ~motor_run;
  assign drv_read    = ctrl_q[2];
  assign mirror_vert = ctrl_q[3];
  assign crc_ctl     = ctrl_q[4];
  assign scan_gap    = ctrl_q[6];
  assign xfer_irq_en = ctrl_q[7];
  assign ext_out     = ext_q;

  always_comb begin
    rdata = '0;
    if (addr == STAT_ADDR)
      rdata = {1'b0, 1'b1, 3'b000, sync_s[2], rdy_q, sync_s[0]};
    else if (addr == EXT_RD_ADDR)
      rdata[EXT_W-1:0] = sync_s[SW-1:3] & ext_q;
  end
endmodule

// File: rtl/drive_ctl_regs_chk.sv
module drive_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] addr,
  input logic [7:0] rdata,
  input logic       drv_stop_n,
  input logic       drv_motor_n,
  input logic [7:0] ext_out,
  input logic       rdy_q
);
  assert_stop_overrides_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_stop_n |-> drv_motor_n);

  assert_ready_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_motor_n |=> rdy_q);

  assert_ready_falls_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> $past(!drv_motor_n));

  assert_status_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'h2) |-> (rdata[6] && !rdata[7] && rdata[5:3] == 3'b000));

  assert_power_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'h3 && !ext_out[7]) |-> !rdata[7]);

  assert_unused_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 4'h2 && addr != 4'h3) |-> rdata == 8'h00);
endmodule

bind drive_ctl_regs drive_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata),
  .drv_stop_n(drv_stop_n), .drv_motor_n(drv_motor_n),
  .ext_out(ext_out), .rdy_q(rdy_q)
);

// File: tb/drive_ctl_regs_tb.sv
`timescale 1ns/1ps
module drive_ctl_regs_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata, ext_out, ext_in = 8'hFF;
  logic drv_stop_n, drv_motor_n, drv_read, mirror_vert, crc_ctl, scan_gap, xfer_irq_en;
  logic drv_present_n = 1, drv_head_n = 1, drv_wren_n = 1;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  drive_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .drv_stop_n(drv_stop_n), .drv_motor_n(drv_motor_n), .drv_read(drv_read),
    .mirror_vert(mirror_vert), .crc_ctl(crc_ctl), .scan_gap(scan_gap),
    .xfer_irq_en(xfer_irq_en), .ext_out(ext_out), .drv_present_n(drv_present_n),
    .drv_head_n(drv_head_n), .drv_wren_n(drv_wren_n), .ext_in(ext_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [6:0] ctrl_exp(input logic [7:0] w);
    return {w[7], w[6], w[4], w[3], w[2], ~(w[0] & ~w[1]), w[0]};
  endfunction

  function automatic logic [6:0] ctrl_act();
    return {xfer_irq_en, scan_gap, crc_ctl, mirror_vert, drv_read, drv_motor_n, drv_stop_n};
  endfunction

  function automatic logic [7:0] stat_exp(input logic rdy);
    return {1'b0, 1'b1, 3'b000, drv_wren_n, rdy, drv_present_n};
  endfunction

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles(2); rst_n = 1; cycles(1);
    // R1 reset values
    check("R1 ctrl", {25'd0, ctrl_act()}, {25'd0, ctrl_exp(8'h2E)});
    check("R1 ext", {24'd0, ext_out}, 32'hFF);

    // R2 R3 control sweep
    for (int w = 0; w < 256; w++) begin
      wr(4'h5, w[7:0]);
      check("R2 R3 ctrl sweep", {25'd0, ctrl_act()}, {25'd0, ctrl_exp(w[7:0])});
    end

    // R9 writes to other offsets ignored
    wr(4'h5, 8'hA5);
    wr(4'h6, 8'h3C);
    for (int a = 0; a < 16; a++) if (a != 5 && a != 6) wr(a[3:0], 8'h5A);
    check("R9 ctrl kept", {25'd0, ctrl_act()}, {25'd0, ctrl_exp(8'hA5)});
    check("R9 ext kept", {24'd0, ext_out}, 32'h3C);

    // R7 R9 address sweep with several input patterns
    for (int p = 0; p < 4; p++) begin
      drv_present_n = p[0]; drv_wren_n = p[1]; ext_in = 8'hF0;
      cycles(3);
      for (int a = 0; a < 16; a++) begin
        addr = a[3:0]; #1;
        if (a == 2) check("R7 status", {24'd0, rdata}, {24'd0, stat_exp(1'b1)});
        else if (a == 3) check("R8 ext read", {24'd0, rdata}, 32'h30);
        else check("R9 unused read", {24'd0, rdata}, 32'h0);
      end
    end

    // R8 expansion sweep
    begin
      logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h81};
      for (int o = 0; o < 256; o++) begin
        wr(4'h6, o[7:0]);
        check("R9 ext write", {24'd0, ext_out}, {24'd0, o[7:0]});
        for (int k = 0; k < 5; k++) begin
          ext_in = pats[k]; addr = 4'h3; cycles(3);
          check("R8 ext and", {24'd0, rdata}, {24'd0, pats[k] & o[7:0]});
        end
      end
    end

    // R10 synchronizer latency
    addr = 4'h2; drv_present_n = 1; cycles(3);
    @(negedge clk); drv_present_n = 0;
    @(negedge clk);
    check("R10 after one edge", {31'd0, rdata[0]}, 32'd1);
    @(negedge clk);
    check("R10 after two edges", {31'd0, rdata[0]}, 32'd0);

    // R4 R5 ready with motor on
    wr(4'h5, 8'h25); addr = 4'h2; cycles(4);
    check("R4 ready idle", {31'd0, rdata[1]}, 32'd1);
    drv_head_n = 0; cycles(4);
    check("R4 ready cleared", {31'd0, rdata[1]}, 32'd0);
    cycles(10);
    check("R4 ready held", {31'd0, rdata[1]}, 32'd0);
    drv_head_n = 1; cycles(4);
    check("R5 inner end", {31'd0, rdata[1]}, 32'd1);

    // R6 motor released
    drv_head_n = 0; cycles(4);
    check("R4 second fall", {31'd0, rdata[1]}, 32'd0);
    wr(4'h5, 8'h27); addr = 4'h2; cycles(1);
    check("R6 motor released", {31'd0, rdata[1]}, 32'd1);
    drv_head_n = 1; cycles(4); drv_head_n = 0; cycles(4);
    check("R6 edge ignored motor off", {31'd0, rdata[1]}, 32'd1);
    // R3 R6 stop active with bit 1 low
    drv_head_n = 1; wr(4'h5, 8'h24); addr = 4'h2; cycles(4);
    drv_head_n = 0; cycles(4);
    check("R3 stop overrides", {31'd0, drv_motor_n}, 32'd1);
    check("R6 edge ignored stopped", {31'd0, rdata[1]}, 32'd1);
    // motor on while head already low: no edge, stays ready
    wr(4'h5, 8'h25); addr = 4'h2; cycles(4);
    check("R4 no edge no clear", {31'd0, rdata[1]}, 32'd1);

    // R1 reset again
    rst_n = 0; cycles(1);
    check("R1 ctrl after reset", {25'd0, ctrl_act()}, {25'd0, ctrl_exp(8'h2E)});
    check("R1 ext after reset", {24'd0, ext_out}, 32'hFF);
    rst_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule